// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit holds the privileged control state of a small 32-bit processor core: the saved exception PC, the cause register, a status register with current and previous copies of the interrupt enable and the user-mode bit, and a mask over a set of fixed-priority external interrupt request lines. The pipeline's commit logic presents the PC of the instruction at the commit point. Alongside that PC it can raise a synchronous exception request, marked either as restartable or as a completed trap, or a return-from-exception request. The unit answers in the same cycle with a fetch redirect address and updates its state on the next clock edge.

External interrupts are injected at the commit point. They win over any synchronous request in the same cycle, and they are only taken while the current enable bit is set. On every entry, the current enable and mode bits are pushed into the previous copies, and the unit switches to kernel mode with interrupts off. This lets a handler save the EPC before it re-enables interrupts for nesting. A return pops the previous copies back. Software reads and writes the four registers through a small move port, which is used to save and restore state around nested handlers.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, EPC, CAUSE, STATUS and MASK all read as zero, which means kernel mode with interrupts disabled. No redirect is signalled while no request is present.
- R2: The move port selects EPC at address 0, CAUSE at 1, STATUS at 2 and MASK at 3. A read is combinational. A write takes effect at the next clock edge. CAUSE keeps bit 31 and bits 4:0. STATUS keeps bits 3:0. MASK keeps one bit per request line, and unused upper bits read as zero.
- R3: A request line i is a candidate when it is high and MASK bit i is set. When the commit slot is valid and STATUS bit 0 (current enable) is 1, the candidate with the lowest index is taken. CAUSE then becomes bit 31 set with code i.
- R4: While STATUS bit 0 is 0, or while every pending line is masked off, no interrupt is taken and no redirect is produced for it.
- R5: On an interrupt, EPC receives the commit PC and fetch is redirected to the handler vector (default 0x80). STATUS bit 2 receives the old bit 0 and bit 3 receives the old bit 1. Bit 0 (enable) and bit 1 (user mode) are then cleared.
- R6: A restartable exception saves the commit PC into EPC, saves CAUSE with bit 31 clear and the given code, redirects to the handler vector, and does the same STATUS push as R5.
- R7: A trap saves the commit PC plus 4 into EPC, redirects to the trap vector (default 0x1010), records its code in CAUSE, and does the same STATUS push.
- R8: When an interrupt is taken in the same cycle as a synchronous exception request, the interrupt wins. EPC and CAUSE then describe the interrupt.
- R9: A return request gives the current EPC as the redirect address. At the next edge, STATUS bit 0 is loaded from bit 2 and bit 1 is loaded from bit 3.
- R10: A move-port write issued in a cycle that also takes an interrupt, exception, trap or return has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_IRQ | External interrupt request lines, index 0 highest priority |
| cmt_valid | input | 1 | An instruction sits at the commit point |
| cmt_pc | input | XLEN | PC of the instruction at the commit point |
| exc_req | input | 1 | Synchronous exception or trap request |
| exc_trap | input | 1 | 1: completed trap, 0: restartable exception |
| exc_code | input | CAUSE_W | Cause code of the synchronous request |
| eret_req | input | 1 | Return-from-exception request |
| csr_wr_en | input | 1 | Move-port write strobe |
| csr_addr | input | 2 | Move-port register select |
| csr_wdata | input | XLEN | Move-port write data |
| csr_rdata | output | XLEN | Move-port read data |
| redirect_valid | output | 1 | Fetch must be redirected this cycle |
| redirect_pc | output | XLEN | Redirect target |
| irq_taken | output | 1 | An external interrupt is taken this cycle |
| stat_ie | output | 1 | Current interrupt enable |
| stat_user | output | 1 | Current mode, 1 is user |

## Verification
The assertions assume that the commit logic holds the commit PC steady within the cycle and never raises a return together with an exception request. They also assume that only the lowest-index pending line matters for a given cycle. The directed stimulus drives each request alone or in the one deliberate conflict (interrupt against exception), and every request lasts exactly one cycle. Register moves happen in idle cycles, except in the scenario that checks a write colliding with an event.

// File: rtl/exc_ctrl_pkg.sv
// Shared types for the exception and interrupt control unit.
package exc_ctrl_pkg;

    // Move-port register selects; software depends on these codes.
    typedef enum logic [1:0] {
        REG_EPC    = 2'd0,
        REG_CAUSE  = 2'd1,
        REG_STATUS = 2'd2,
        REG_MASK   = 2'd3
    } ctl_reg_e;

    // Status layout from bit 3 down to bit 0.
    typedef struct packed {
        logic pum;   // previous user mode
        logic pie;   // previous interrupt enable
        logic um;    // current user mode (1 = user)
        logic ie;    // current interrupt enable
    } status_t;

endpackage

// File: rtl/exc_irq_pick.sv
// Masks the request lines and picks the lowest-index live line.
// Assumes N >= 1; index 0 has the highest priority.
module exc_irq_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     mask,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] live;
    logic         found;

    assign live = req & mask;
    assign any  = |live;

    // Priority encode: first live line from index 0 upward.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (live[i] && !found) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_status_reg.sv
// Status register with a one-deep push/pop of enable and mode.
// Assumes enter and leave are never high together (top guarantees it).
module exc_status_reg
    import exc_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enter,
    input  logic    leave,
    input  logic    wr_en,
    input  status_t wdata,
    output status_t st
);
    // Push on entry, pop on return, else accept a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (enter) begin
            st.pie <= st.ie;
            st.pum <= st.um;
            st.ie  <= 1'b0;
            st.um  <= 1'b0;
        end else if (leave) begin
            st.ie <= st.pie;
            st.um <= st.pum;
        end else if (wr_en) begin
            st <= wdata;
        end
    end
endmodule

// File: rtl/exc_save_regs.sv
// EPC, cause and interrupt mask registers.
// Assumes wr_en is already suppressed by the top during events.
module exc_save_regs
    import exc_ctrl_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5,
    parameter int N_IRQ   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter,
    input  logic [XLEN-1:0]    enter_pc,
    input  logic               enter_irq,
    input  logic [CAUSE_W-1:0] enter_code,
    input  logic               wr_en,
    input  ctl_reg_e           wr_sel,
    input  logic [XLEN-1:0]    wdata,
    output logic [XLEN-1:0]    epc,
    output logic               cause_irq,
    output logic [CAUSE_W-1:0] cause_code,
    output logic [N_IRQ-1:0]   mask
);
    // Exception PC: captured on entry or written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                              epc <= '0;
        else if (enter)                          epc <= enter_pc;
        else if (wr_en && wr_sel == REG_EPC)     epc <= wdata;
    end

    // Cause: interrupt flag plus code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_irq  <= 1'b0;
            cause_code <= '0;
        end else if (enter) begin
            cause_irq  <= enter_irq;
            cause_code <= enter_code;
        end else if (wr_en && wr_sel == REG_CAUSE) begin
            cause_irq  <= wdata[XLEN-1];
            cause_code <= wdata[CAUSE_W-1:0];
        end
    end

    // Interrupt mask: software only.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask <= '0;
        else if (wr_en && wr_sel == REG_MASK)    mask <= wdata[N_IRQ-1:0];
    end
endmodule

// File: rtl/exc_ctrl_unit.sv
// Exception and interrupt control unit top.
// Arbitrates interrupt > exception/trap > return at the commit point,
// produces the fetch redirect combinationally and updates state next edge.
// Assumes CAUSE_W can hold an interrupt index and N_IRQ < XLEN.
module exc_ctrl_unit
    import exc_ctrl_pkg::*;
#(
    parameter int          XLEN           = 32,
    parameter int          N_IRQ          = 8,
    parameter int          CAUSE_W        = 5,
    parameter logic [31:0] HANDLER_VECTOR = 32'h0000_0080,
    parameter logic [31:0] TRAP_VECTOR    = 32'h0000_1010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic               cmt_valid,
    input  logic [XLEN-1:0]    cmt_pc,
    input  logic               exc_req,
    input  logic               exc_trap,
    input  logic [CAUSE_W-1:0] exc_code,
    input  logic               eret_req,
    input  logic               csr_wr_en,
    input  logic [1:0]         csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               irq_taken,
    output logic               stat_ie,
    output logic               stat_user
);
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    status_t            st_q;
    logic [XLEN-1:0]    epc_q;
    logic               cause_irq_q;
    logic [CAUSE_W-1:0] cause_code_q;
    logic [N_IRQ-1:0]   mask_q;
    logic               irq_any;
    logic [IDX_W-1:0]   irq_idx;
    logic               take_exc;
    logic               take_ret;
    logic               enter;
    logic [XLEN-1:0]    enter_pc;
    logic [CAUSE_W-1:0] enter_code;
    logic               wr_ok;
    ctl_reg_e           sel;

    assign sel = ctl_reg_e'(csr_addr);

    exc_irq_pick #(.N(N_IRQ), .IDX_W(IDX_W)) pick_i (
        .req  (irq_req),
        .mask (mask_q),
        .any  (irq_any),
        .idx  (irq_idx)
    );

    // Event arbitration at the commit point.
    always_comb begin
        irq_taken  = cmt_valid && st_q.ie && irq_any;
        take_exc   = exc_req && !irq_taken;
        take_ret   = eret_req && !irq_taken && !exc_req;
        enter      = irq_taken || take_exc;
        enter_pc   = (take_exc && exc_trap) ? cmt_pc + XLEN'(4) : cmt_pc;
        enter_code = irq_taken ? CAUSE_W'(irq_idx) : exc_code;
        wr_ok      = csr_wr_en && !enter && !take_ret;
    end

    // Redirect target selection.
    always_comb begin
        redirect_valid = enter || take_ret;
        if (take_ret)                   redirect_pc = epc_q;
        else if (take_exc && exc_trap)  redirect_pc = XLEN'(TRAP_VECTOR);
        else                            redirect_pc = XLEN'(HANDLER_VECTOR);
    end

    exc_status_reg status_i (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (enter),
        .leave (take_ret),
        .wr_en (wr_ok && sel == REG_STATUS),
        .wdata (status_t'(csr_wdata[3:0])),
        .st    (st_q)
    );

    exc_save_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .N_IRQ(N_IRQ)) save_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (enter),
        .enter_pc   (enter_pc),
        .enter_irq  (irq_taken),
        .enter_code (enter_code),
        .wr_en      (wr_ok),
        .wr_sel     (sel),
        .wdata      (csr_wdata),
        .epc        (epc_q),
        .cause_irq  (cause_irq_q),
        .cause_code (cause_code_q),
        .mask       (mask_q)
    );

    // Move-port read mux.
    always_comb begin
        unique case (sel)
            REG_EPC:    csr_rdata = epc_q;
            REG_CAUSE:  csr_rdata = {cause_irq_q, {(XLEN-1-CAUSE_W){1'b0}}, cause_code_q};
            REG_STATUS: csr_rdata = {{(XLEN-4){1'b0}}, st_q};
            default:    csr_rdata = {{(XLEN-N_IRQ){1'b0}}, mask_q};
        endcase
    end

    assign stat_ie   = st_q.ie;
    assign stat_user = st_q.um;
endmodule

// File: rtl/exc_ctrl_unit_chk.sv
// Property checker for exc_ctrl_unit, attached by bind.
module exc_ctrl_unit_chk #(
    parameter int          XLEN        = 32,
    parameter logic [31:0] TRAP_VECTOR = 32'h0000_1010
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_taken,
    input logic            exc_req,
    input logic            exc_trap,
    input logic            eret_req,
    input logic [XLEN-1:0] cmt_pc,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] epc,
    input logic            st_ie,
    input logic            st_um,
    input logic            st_pie,
    input logic            st_pum
);
    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> st_ie);

    assert_entry_kernel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> (!st_ie && !st_um));

    assert_entry_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> (st_pie == $past(st_ie) && st_pum == $past(st_um)));

    assert_irq_epc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> epc == $past(cmt_pc));

    assert_trap_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_trap && !irq_taken) |-> redirect_pc == XLEN'(TRAP_VECTOR));

    assert_trap_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_trap && !irq_taken) |=> epc == $past(cmt_pc) + XLEN'(4));

    assert_ret_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !exc_req && !irq_taken) |=> (st_ie == $past(st_pie) && st_um == $past(st_pum)));
endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk #(.XLEN(XLEN), .TRAP_VECTOR(TRAP_VECTOR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_taken   (irq_taken),
    .exc_req     (exc_req),
    .exc_trap    (exc_trap),
    .eret_req    (eret_req),
    .cmt_pc      (cmt_pc),
    .redirect_pc (redirect_pc),
    .epc         (epc_q),
    .st_ie       (st_q.ie),
    .st_um       (st_q.um),
    .st_pie      (st_q.pie),
    .st_pum      (st_q.pum)
);

// File: tb/exc_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checks its own results.
module exc_ctrl_unit_tb_top;
    localparam int XLEN = 32;
    localparam int N    = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_req = '0;
    logic            cmt_valid = 1'b0;
    logic [XLEN-1:0] cmt_pc = '0;
    logic            exc_req = 1'b0;
    logic            exc_trap = 1'b0;
    logic [4:0]      exc_code = '0;
    logic            eret_req = 1'b0;
    logic            csr_wr_en = 1'b0;
    logic [1:0]      csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic            irq_taken;
    logic            stat_ie;
    logic            stat_user;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    exc_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cmt_valid(cmt_valid),
        .cmt_pc(cmt_pc), .exc_req(exc_req), .exc_trap(exc_trap), .exc_code(exc_code),
        .eret_req(eret_req), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .irq_taken(irq_taken), .stat_ie(stat_ie),
        .stat_user(stat_user)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        irq_req = '0; cmt_valid = 1'b0; exc_req = 1'b0; exc_trap = 1'b0;
        exc_code = '0; eret_req = 1'b0; csr_wr_en = 1'b0;
    endtask

    // Read a register through the move port (combinational).
    task automatic rd(input logic [1:0] a, output logic [XLEN-1:0] v);
        @(negedge clk);
        csr_addr = a;
        #1 v = csr_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [XLEN-1:0] v);
        @(negedge clk);
        csr_addr = a; csr_wdata = v; csr_wr_en = 1'b1;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] a, input logic [XLEN-1:0] exp);
        logic [XLEN-1:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        #1;
        check("R1 redirect", {31'd0, redirect_valid}, 32'd0);
        check("R1 irq_taken", {31'd0, irq_taken}, 32'd0);
        expect_reg("R1 epc", 2'd0, 32'd0);
        expect_reg("R1 cause", 2'd1, 32'd0);
        expect_reg("R1 status", 2'd2, 32'd0);
        expect_reg("R1 mask", 2'd3, 32'd0);
    endtask

    task automatic t_moves();
        wr(2'd0, 32'h0000_1234);
        expect_reg("R2 epc write", 2'd0, 32'h0000_1234);
        wr(2'd1, 32'hFFFF_FFE7);
        expect_reg("R2 cause write", 2'd1, 32'h8000_0007);
        wr(2'd2, 32'hFFFF_FFF5);
        expect_reg("R2 status write", 2'd2, 32'h0000_0005);
        wr(2'd3, 32'hFFFF_FFFF);
        expect_reg("R2 mask write", 2'd3, 32'h0000_00FF);
        wr(2'd2, 32'd0);
    endtask

    task automatic t_irq_blocked();
        @(negedge clk);
        irq_req = 8'h10; cmt_valid = 1'b1; cmt_pc = 32'h500;
        #1;
        check("R4 disabled no take", {31'd0, irq_taken}, 32'd0);
        check("R4 disabled no redirect", {31'd0, redirect_valid}, 32'd0);
        idle();
        wr(2'd2, 32'h1);
        wr(2'd3, 32'hEF);
        @(negedge clk);
        irq_req = 8'h10; cmt_valid = 1'b1;
        #1;
        check("R4 masked no take", {31'd0, irq_taken}, 32'd0);
        idle();
        wr(2'd3, 32'hFF);
        wr(2'd2, 32'h3);
    endtask

    task automatic t_irq_priority();
        @(negedge clk);
        irq_req = 8'hA4; cmt_valid = 1'b1; cmt_pc = 32'h2000;
        #1;
        check("R3 taken", {31'd0, irq_taken}, 32'd1);
        check("R5 vector", redirect_pc, 32'h80);
        @(negedge clk);
        idle();
        expect_reg("R3 cause lowest index", 2'd1, 32'h8000_0002);
        expect_reg("R5 epc", 2'd0, 32'h2000);
        expect_reg("R5 status push", 2'd2, 32'hC);
        @(negedge clk);
        irq_req = 8'h04; cmt_valid = 1'b1;
        #1;
        check("R4 inside handler no take", {31'd0, irq_taken}, 32'd0);
        idle();
    endtask

    task automatic do_eret(input string req, input logic [XLEN-1:0] exp_pc, input logic [XLEN-1:0] exp_st);
        @(negedge clk);
        eret_req = 1'b1;
        #1;
        check({req, " resume"}, redirect_pc, exp_pc);
        @(negedge clk);
        idle();
        expect_reg({req, " status pop"}, 2'd2, exp_st);
    endtask

    task automatic t_exception();
        @(negedge clk);
        exc_req = 1'b1; exc_code = 5'd3; cmt_valid = 1'b1; cmt_pc = 32'h3000;
        #1;
        check("R6 vector", redirect_pc, 32'h80);
        @(negedge clk);
        idle();
        expect_reg("R6 epc", 2'd0, 32'h3000);
        expect_reg("R6 cause", 2'd1, 32'h3);
        expect_reg("R6 status", 2'd2, 32'hC);
        do_eret("R9 after exception", 32'h3000, 32'hF);
    endtask

    task automatic t_trap();
        @(negedge clk);
        exc_req = 1'b1; exc_trap = 1'b1; exc_code = 5'd9; cmt_valid = 1'b1; cmt_pc = 32'h11A0;
        #1;
        check("R7 vector", redirect_pc, 32'h1010);
        @(negedge clk);
        idle();
        expect_reg("R7 epc plus 4", 2'd0, 32'h11A4);
        expect_reg("R7 cause", 2'd1, 32'h9);
        do_eret("R9 after trap", 32'h11A4, 32'hF);
    endtask

    task automatic t_override();
        @(negedge clk);
        irq_req = 8'h40; cmt_valid = 1'b1; cmt_pc = 32'h4000;
        exc_req = 1'b1; exc_trap = 1'b1; exc_code = 5'd4;
        #1;
        check("R8 irq wins", {31'd0, irq_taken}, 32'd1);
        check("R8 vector", redirect_pc, 32'h80);
        @(negedge clk);
        idle();
        expect_reg("R8 cause", 2'd1, 32'h8000_0006);
        expect_reg("R8 epc", 2'd0, 32'h4000);
    endtask

    task automatic t_write_collision();
        @(negedge clk);
        eret_req = 1'b1; csr_wr_en = 1'b1; csr_addr = 2'd0; csr_wdata = 32'hDEAD;
        #1;
        check("R10 eret resume", redirect_pc, 32'h4000);
        @(negedge clk);
        idle();
        expect_reg("R10 epc kept", 2'd0, 32'h4000);
        @(negedge clk);
        exc_req = 1'b1; exc_code = 5'd2; cmt_valid = 1'b1; cmt_pc = 32'h6000;
        csr_wr_en = 1'b1; csr_addr = 2'd2; csr_wdata = 32'h0;
        @(negedge clk);
        idle();
        expect_reg("R10 status not written", 2'd2, 32'hC);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_moves();
        t_irq_blocked();
        t_irq_priority();
        do_eret("R9 after interrupt", 32'h2000, 32'hF);
        t_exception();
        t_trap();
        t_override();
        t_write_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule